// File: doc/BRIEF.md
# Instruction Prefetch Unit

This block runs ahead of the decode stage and keeps a small store of instruction words ready for it. It reads 32-bit words from a read-only request/grant/response bus, one word per transaction, and always puts a word-aligned address on the bus. Fetching is sequential and speculative. After reset it starts at a fixed address. After a redirect it starts at the redirect target. Because it runs ahead, it may read a few words past the end of the code that actually runs.

Fetched words go into a four-entry buffer. The decode side takes them through a valid/ready handshake, and each word comes with the address it was read from. A new bus request is raised only when the buffered words plus the transactions in flight number fewer than four, so every answer already has a slot waiting for it. At most two transactions are in flight at once.

A redirect empties the buffer. Answers to requests that were granted before the redirect are counted and thrown away. If a request is still waiting for its grant when the redirect comes, that request stays on the bus unchanged until it is granted. Its answer is then thrown away as well, and fetching continues from the new target.

Top module: `ifetch_prefetch`

## Requirements
- R1: Every bus address has bits [1:0] equal to 0; a redirect target is used with its two low bits cleared.
- R2: Once the request is raised, it stays high with an unchanged address until the cycle in which grant is high.
- R3: No more than two transactions are granted but not yet answered at any time.
- R4: A request is raised only while buffered words plus in-flight transactions are fewer than four. With the consumer stalled from reset, exactly four words are granted, then the request stays low and the buffer never overflows.
- R5: Each sequential grant advances the fetch address by 4. Each delivered word carries the address it was read from.
- R6: Words are delivered in fetch order. While the output is valid and ready is low, the output word and its address hold.
- R7: In the cycle after a redirect, the output is not valid.
- R8: Answers to requests that were in flight at a redirect are discarded. The first word delivered after a redirect is the one at the aligned target.
- R9: A redirect that comes while a request waits for its grant leaves that request and its address unchanged on the bus. Its answer is discarded, and fetching then continues from the target.
- R10: A kept answer becomes visible at the output in the cycle after the cycle in which its response valid is high.
- R11: After reset the output is not valid, and the first request is for the reset address (default 0x0000_1000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| redirect_i | input | 1 | Restart fetching at redirect_addr_i |
| redirect_addr_i | input | 32 | Redirect target; the two low bits are ignored |
| bus_req_o | output | 1 | Read request valid |
| bus_addr_o | output | 32 | Word-aligned read address |
| bus_gnt_i | input | 1 | Request accepted this cycle |
| bus_rvalid_i | input | 1 | Read data valid for one cycle per granted request |
| bus_rdata_i | input | DATA_W | Read data |
| out_valid_o | output | 1 | A fetched word is available |
| out_ready_i | input | 1 | Consumer takes the word this cycle |
| out_data_o | output | DATA_W | Fetched instruction word |
| out_addr_o | output | 32 | Address of the fetched word |

## Verification
If the in-flight count or the drop count is wrong, the error shows up at the output as a word whose address is off by whole words. It can also show up as a grant count above two or as a stall that never ends, and it appears as soon as the first answer after a redirect is delivered. If the fetch address or the answer address drifts, the very next delivered word breaks the expected sequence of addresses and data. If the space reservation is wrong, the stalled consumer case shows it within a few cycles: the count of grants after reset is no longer four. A request held badly across a redirect changes the bus address during a wait for grant, and this is visible in the cycle after the redirect.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned AW = 32;
  localparam int unsigned WORD_BYTES = 4;

  // Clear the byte offset inside a word.
  function automatic logic [AW-1:0] word_align(input logic [AW-1:0] a);
    return {a[AW-1:2], 2'b00};
  endfunction

  // Address of the following sequential word.
  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a);
    return a + AW'(WORD_BYTES);
  endfunction
endpackage

// File: rtl/pf_fifo.sv
module pf_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic [AW-1:0]                push_addr,
  input  logic                         pop,
  output logic                         valid,
  output logic [DW-1:0]                rd_data,
  output logic [AW-1:0]                rd_addr,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [DW-1:0] data_mem [DEPTH];
  logic [AW-1:0] addr_mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  assign do_pop = pop && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      data_mem[wr_ptr] <= push_data;
      addr_mem[wr_ptr] <= push_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push)   wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop) rd_ptr <= ptr_inc(rd_ptr);
      cnt_q <= cnt_q + CW'(push) - CW'(do_pop);
    end
  end

  assign valid   = (cnt_q != '0);
  assign rd_data = data_mem[rd_ptr];
  assign rd_addr = addr_mem[rd_ptr];
  assign count   = cnt_q;
  assign full    = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/pf_fetch_ctrl.sv
module pf_fetch_ctrl
  import pf_pkg::*;
#(
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned MAX_OUT    = 2,
  parameter logic [31:0] RESET_ADDR = 32'h0000_1000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        redirect,
  input  logic [AW-1:0]               redirect_addr,
  input  logic                        gnt,
  input  logic                        rvalid,
  input  logic [$clog2(DEPTH+1)-1:0]  fifo_count,
  output logic                        req,
  output logic [AW-1:0]               addr,
  output logic                        push,
  output logic [AW-1:0]               push_addr,
  output logic                        gnt_evt,
  output logic                        rsp_evt,
  output logic                        drop_evt,
  output logic [$clog2(DEPTH+1)-1:0]  outstanding
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic          pend_q;
  logic          stale_q, stale_n;
  logic [AW-1:0] saved_q, saved_n;
  logic [AW-1:0] fetch_q, fetch_n;
  logic [AW-1:0] rsp_q, rsp_n;
  logic [CW-1:0] out_q, out_n;
  logic [CW-1:0] drop_q, drop_n;
  logic [CW:0]   reserved;
  logic          space_ok, cap_ok;

  // Words held plus words on their way must leave room for another.
  assign reserved = {1'b0, fifo_count} + {1'b0, out_q};
  assign space_ok = reserved < (CW+1)'(DEPTH);
  assign cap_ok   = out_q < CW'(MAX_OUT);

  assign req      = pend_q || (space_ok && cap_ok && !redirect);
  assign addr     = fetch_q;
  assign gnt_evt  = req && gnt;
  assign rsp_evt  = rvalid && (out_q != '0);
  assign drop_evt = rsp_evt && (drop_q != '0);
  assign push     = rsp_evt && !drop_evt && !redirect;
  assign push_addr = rsp_q;
  assign outstanding = out_q;

  assign out_n = out_q + CW'(gnt_evt) - CW'(rsp_evt);

  always_comb begin
    stale_n = stale_q;
    saved_n = saved_q;
    fetch_n = fetch_q;
    rsp_n   = rsp_q;
    drop_n  = drop_q - CW'(drop_evt) + CW'(gnt_evt && stale_q);
    if (redirect) begin
      drop_n = out_n;
      rsp_n  = word_align(redirect_addr);
      if (req && !gnt) begin
        stale_n = 1'b1;
        saved_n = word_align(redirect_addr);
      end else begin
        stale_n = 1'b0;
        fetch_n = word_align(redirect_addr);
      end
    end else begin
      if (gnt_evt) begin
        if (stale_q) begin
          fetch_n = saved_q;
          stale_n = 1'b0;
        end else begin
          fetch_n = next_word(fetch_q);
        end
      end
      if (push) rsp_n = next_word(rsp_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
      saved_q <= '0;
      fetch_q <= word_align(RESET_ADDR);
      rsp_q   <= word_align(RESET_ADDR);
      out_q   <= '0;
      drop_q  <= '0;
    end else begin
      pend_q  <= req && !gnt;
      stale_q <= stale_n;
      saved_q <= saved_n;
      fetch_q <= fetch_n;
      rsp_q   <= rsp_n;
      out_q   <= out_n;
      drop_q  <= drop_n;
    end
  end
endmodule

// File: rtl/ifetch_prefetch.sv
module ifetch_prefetch
  import pf_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned MAX_OUT    = 2,
  parameter logic [31:0] RESET_ADDR = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_i,
  input  logic [31:0]       redirect_addr_i,
  output logic              bus_req_o,
  output logic [31:0]       bus_addr_o,
  input  logic              bus_gnt_i,
  input  logic              bus_rvalid_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [31:0]       out_addr_o
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  // Internal events brought out for the checker.
  logic          push_evt;
  logic          gnt_evt;
  logic          rsp_evt;
  logic          drop_evt;
  logic          fifo_full;
  logic [CW-1:0] fifo_count;
  logic [CW-1:0] outstanding;
  logic [AW-1:0] push_addr;

  pf_fetch_ctrl #(
    .DEPTH(DEPTH), .MAX_OUT(MAX_OUT), .RESET_ADDR(RESET_ADDR)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .redirect(redirect_i), .redirect_addr(redirect_addr_i),
    .gnt(bus_gnt_i), .rvalid(bus_rvalid_i), .fifo_count(fifo_count),
    .req(bus_req_o), .addr(bus_addr_o),
    .push(push_evt), .push_addr(push_addr),
    .gnt_evt(gnt_evt), .rsp_evt(rsp_evt), .drop_evt(drop_evt),
    .outstanding(outstanding)
  );

  pf_fifo #(
    .DW(DATA_W), .AW(AW), .DEPTH(DEPTH)
  ) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(redirect_i),
    .push(push_evt), .push_data(bus_rdata_i), .push_addr(push_addr),
    .pop(out_ready_i),
    .valid(out_valid_o), .rd_data(out_data_o), .rd_addr(out_addr_o),
    .count(fifo_count), .full(fifo_full)
  );
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned MAX_OUT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redirect_i,
  input logic              bus_req_o,
  input logic [31:0]       bus_addr_o,
  input logic              bus_gnt_i,
  input logic              bus_rvalid_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic [31:0]       out_addr_o,
  input logic              push_evt,
  input logic              drop_evt,
  input logic              fifo_full
);
  logic [3:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 4'(bus_req_o && bus_gnt_i)
                              - 4'(bus_rvalid_i && inflight != '0);
  end

  assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> bus_addr_o[1:0] == 2'b00);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o));

  assert_max_inflight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 4'(MAX_OUT));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |-> !fifo_full);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i && !redirect_i |=>
      out_valid_o && $stable(out_data_o) && $stable(out_addr_o));

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> !out_valid_o);

  assert_drop_no_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> !push_evt);
endmodule

bind ifetch_prefetch pf_checker #(.DATA_W(DATA_W), .MAX_OUT(MAX_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .redirect_i(redirect_i),
  .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o), .bus_gnt_i(bus_gnt_i),
  .bus_rvalid_i(bus_rvalid_i), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .out_data_o(out_data_o), .out_addr_o(out_addr_o),
  .push_evt(push_evt), .drop_evt(drop_evt), .fifo_full(fifo_full)
);

// File: tb/ifetch_prefetch_tb_top.sv
module ifetch_prefetch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BOOT = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redirect_i = 1'b0;
  logic [31:0] redirect_addr_i = '0;
  logic        bus_req_o;
  logic [31:0] bus_addr_o;
  logic        bus_gnt_i = 1'b0;
  logic        bus_rvalid_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [31:0] out_data_o;
  logic [31:0] out_addr_o;

  int n_checks = 0;
  int n_fail = 0;

  ifetch_prefetch dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], a[31:16] ^ 16'hC3C3};
  endfunction

  // Scoreboard queue of expected word addresses.
  logic [31:0] exp_q[$];
  task automatic restart_stream(input logic [31:0] base);
    exp_q.delete();
    for (int i = 0; i < 128; i++) exp_q.push_back({base[31:2], 2'b00} + 32'(4*i));
  endtask

  // Bus responder.
  bit          hold_gnt = 0;
  bit          slow_gnt = 0;
  int          lat = 1;
  int          cyc = 0;
  int          grants = 0;
  logic [31:0] first_gnt_addr = '0;
  logic [31:0] pend_addr[$];
  int          pend_due[$];
  bit          prev_wait = 0;
  logic [31:0] prev_addr = '0;

  always @(negedge clk) begin
    #1;
    cyc++;
    bus_rvalid_i = 1'b0;
    bus_gnt_i = 1'b0;
    if (!rst_n) begin
      pend_addr.delete();
      pend_due.delete();
      prev_wait = 0;
    end else begin
      if (prev_wait)
        check(bus_req_o && bus_addr_o == prev_addr, "R2 request held", bus_addr_o, prev_addr);
      if (pend_addr.size() > 0 && pend_due[0] <= cyc) begin
        bus_rvalid_i = 1'b1;
        bus_rdata_i = mem_word(pend_addr.pop_front());
        void'(pend_due.pop_front());
      end
      if (bus_req_o && !hold_gnt && (!slow_gnt || cyc % 3 == 0)) begin
        bus_gnt_i = 1'b1;
        if (grants == 0) first_gnt_addr = bus_addr_o;
        grants++;
        check(bus_addr_o[1:0] == 2'b00, "R1 aligned address", bus_addr_o, {bus_addr_o[31:2], 2'b00});
        pend_addr.push_back(bus_addr_o);
        pend_due.push_back(cyc + lat);
        check(pend_addr.size() <= 2, "R3 outstanding", 32'(pend_addr.size()), 32'd2);
      end
      prev_wait = bus_req_o && !bus_gnt_i;
      prev_addr = bus_addr_o;
    end
  end

  // Consumer ready pattern: 0 ready, 1 stalled, 2 toggling.
  int ready_mode = 1;
  always @(negedge clk) begin
    case (ready_mode)
      0: out_ready_i = 1'b1;
      1: out_ready_i = 1'b0;
      default: out_ready_i = ~out_ready_i;
    endcase
  end

  // Monitor: compares each accepted word against the scoreboard.
  int n_rx = 0;
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid_o && out_ready_i) begin
      n_rx++;
      if (exp_q.size() == 0) begin
        check(0, "R5 unexpected word", out_addr_o, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] ea;
        ea = exp_q.pop_front();
        check(out_addr_o == ea, "R5/R8 word address", out_addr_o, ea);
        check(out_data_o == mem_word(ea), "R6 word data order", out_data_o, mem_word(ea));
      end
    end
  end

  task automatic do_redirect(input logic [31:0] t);
    @(negedge clk);
    redirect_i = 1'b1;
    redirect_addr_i = t;
    @(negedge clk);
    redirect_i = 1'b0;
    restart_stream(t);
    #3;
    check(out_valid_o == 1'b0, "R7 flushed after redirect", 32'(out_valid_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 32'(cyc), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held_d, held_a, wait_a;
    int rx0;
    restart_stream(BOOT);
    repeat (3) @(negedge clk);
    #3;
    check(out_valid_o == 1'b0, "R11 reset output", 32'(out_valid_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: first kept answer shows up one cycle later.
    do begin @(negedge clk); #3; end while (!bus_rvalid_i);
    check(out_valid_o == 1'b0, "R10 before answer", 32'(out_valid_o), 32'd0);
    @(negedge clk); #3;
    check(out_valid_o == 1'b1, "R10 answer visible", 32'(out_valid_o), 32'd1);
    check(first_gnt_addr == BOOT, "R11 first request", first_gnt_addr, BOOT);

    // R4 / R6: stalled consumer.
    repeat (20) @(negedge clk);
    #3;
    check(grants == 4, "R4 grants while stalled", 32'(grants), 32'd4);
    check(bus_req_o == 1'b0, "R4 request low when full", 32'(bus_req_o), 32'd0);
    held_d = out_data_o; held_a = out_addr_o;
    repeat (5) @(negedge clk);
    #3;
    check(out_data_o == held_d && out_addr_o == held_a, "R6 hold while stalled", out_addr_o, held_a);

    // R5: free running.
    ready_mode = 0;
    repeat (40) @(negedge clk);

    // R8: longer latency, toggling consumer, redirects with traffic in flight.
    lat = 3;
    ready_mode = 2;
    repeat (15) @(negedge clk);
    do_redirect(32'h0000_2002);  // R1: stream restarts at 0x2000
    repeat (3) @(negedge clk);
    do_redirect(32'h0000_3001);
    repeat (40) @(negedge clk);

    // R9: redirect while a request waits for its grant.
    ready_mode = 0;
    hold_gnt = 1;
    repeat (6) @(negedge clk);
    #3;
    check(bus_req_o == 1'b1, "R9 request waiting", 32'(bus_req_o), 32'd1);
    wait_a = bus_addr_o;
    do_redirect(32'h0000_4000);
    check(bus_req_o == 1'b1 && bus_addr_o == wait_a, "R9 waiting request kept", bus_addr_o, wait_a);
    rx0 = n_rx;
    hold_gnt = 0;
    repeat (40) @(negedge clk);
    check(n_rx > rx0 + 5, "R9 stream resumes at target", 32'(n_rx - rx0), 32'd6);

    // Slow grants and a bouncing consumer.
    slow_gnt = 1;
    lat = 2;
    ready_mode = 2;
    do_redirect(32'h0000_5006);
    repeat (60) @(negedge clk);
    ready_mode = 0;
    repeat (20) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule